// File: doc/BRIEF.md
# Secure-to-Non-Secure Call Sequencer

This block carries out the state-changing half of a call from secure code. The core starts it with a one-cycle `start` pulse. With the pulse the core gives the branch target, the address of the following instruction, the stack pointer, the current exception number, the secure floating-point-active control bit, the handler-mode flag and the current security state. Bit 0 of the target picks the state the call lands in.

A call that stays secure is an ordinary link-and-branch. It finishes one cycle after `start` and makes no memory access. A call into non-secure code first pushes a two-word return frame below the stack pointer, through a word-write port with a valid/ready handshake. It then commits, all in one cycle, the new stack pointer, a fixed return token in the link register, the target PC, a masked exception number and the non-secure state. A fault on either store abandons the call and changes none of these registers. A call made from non-secure state is refused as undefined.

The outputs `pc_o`, `lr_o`, `sp_o`, `ipsr_o` and `secure_o` are registers. They change only in the cycle where `done` is high.

Top module: `sec_call_seq`

## Requirements
- R1: After reset, `pc_o`, `lr_o`, `sp_o` and `ipsr_o` are zero and `secure_o` is 1. `done`, `undef`, `aborted`, `misaligned` and `mem_valid` are 0.
- R2: A start taken in secure state whose target has bit 0 = 1 pulses `done` in the next cycle. In that cycle `lr_o` = `next_pc` | 1, `pc_o` = target with bit 0 cleared, `sp_o` = `sp_in`, `ipsr_o` = `exc_num` and `secure_o` = 1. No memory write is issued.
- R3: A start taken in secure state whose target has bit 0 = 0 issues exactly two writes, in this order. The first goes to base = `sp_in` − 8 and carries `next_pc` | 1. The second goes to base + 4 and carries the saved status word.
- R4: The saved status word holds `exc_num` zero-extended in its low bits, with bit 20 equal to `sfp_active`.
- R5: When the second write completes without fault, `done` pulses for one cycle. In that same cycle `sp_o` = base, `lr_o` = 0xFEFFFFFF, `pc_o` = target with bit 0 cleared and `secure_o` = 0.
- R6: On a completed non-secure call, `ipsr_o` becomes 1 if `handler_mode` was set at start and `exc_num` otherwise.
- R7: A start with `cur_secure` = 0 pulses `undef` in the next cycle. It issues no write and leaves all five state outputs unchanged.
- R8: For a non-secure call whose base has bits [2:0] ≠ 0, `misaligned` is high in the cycle that ends the sequence (`done` or `aborted`), and the sequence still runs to completion.
- R9: A write answered with `mem_fault` pulses `aborted`. No further write follows, and the five state outputs keep their previous values.
- R10: A `start` that arrives while a frame push is in progress is ignored.
- R11: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_wdata` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to run the call |
| tgt_addr | input | 32 | Branch target; bit 0 = 1 means a secure destination |
| next_pc | input | 32 | Address of the instruction after the call |
| sp_in | input | 32 | Current stack pointer |
| exc_num | input | EXC_W | Current exception number |
| sfp_active | input | 1 | Secure control floating-point-active bit (bit 3) |
| handler_mode | input | 1 | Core is in handler mode |
| cur_secure | input | 1 | Core is in secure state |
| mem_valid | output | 1 | Write request valid |
| mem_addr | output | 32 | Write address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Write accepted this cycle |
| mem_fault | input | 1 | Accepted write faulted (qualified by ready) |
| done | output | 1 | Call committed (one-cycle pulse) |
| undef | output | 1 | Call refused as undefined (one-cycle pulse) |
| aborted | output | 1 | Frame push faulted (one-cycle pulse) |
| misaligned | output | 1 | Frame base not 8-byte aligned; valid with done/aborted |
| pc_o | output | 32 | Committed program counter |
| lr_o | output | 32 | Committed link register |
| sp_o | output | 32 | Committed stack pointer |
| ipsr_o | output | EXC_W | Committed exception number field |
| secure_o | output | 1 | Committed security state |

## Verification
The alignment report and the end of the sequence fall in the same cycle. A misaligned base therefore has to show up on `misaligned` in exactly the cycle where either `done` or `aborted` rises. The bench provokes both pairings. One is an unaligned stack pointer on a call that commits. The other is an unaligned stack pointer on a call whose second store faults. At the negedge after each terminating pulse, the bench judges both flags against values computed from the stimulus, along with the state outputs and the logged writes.

// File: rtl/sec_call_seq.sv
module sec_call_seq #(
  parameter int EXC_W = 9,
  parameter int PSR_FP_BIT = 20,
  parameter logic [31:0] NS_RET_TOKEN = 32'hFEFF_FFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [31:0]      tgt_addr,
  input  logic [31:0]      next_pc,
  input  logic [31:0]      sp_in,
  input  logic [EXC_W-1:0] exc_num,
  input  logic             sfp_active,
  input  logic             handler_mode,
  input  logic             cur_secure,
  output logic             mem_valid,
  output logic [31:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic             mem_ready,
  input  logic             mem_fault,
  output logic             done,
  output logic             undef,
  output logic             aborted,
  output logic             misaligned,
  output logic [31:0]      pc_o,
  output logic [31:0]      lr_o,
  output logic [31:0]      sp_o,
  output logic [EXC_W-1:0] ipsr_o,
  output logic             secure_o
);

  typedef enum logic [1:0] {S_IDLE, S_RET, S_PSR} st_t;
  st_t st;

  logic [31:0]      base_q, ret_q, psr_q;
  logic [31:1]      tgt_q;
  logic [EXC_W-1:0] exc_q;
  logic             hnd_q, mis_q;

  logic [31:0] base_n, psr_n;
  assign base_n = sp_in - 32'd8;
  assign psr_n  = 32'(exc_num) | (32'(sfp_active) << PSR_FP_BIT);

  wire xfer = mem_valid && mem_ready;

  assign mem_valid = (st != S_IDLE);
  assign mem_addr  = (st == S_PSR) ? base_q + 32'd4 : base_q;
  assign mem_wdata = (st == S_PSR) ? psr_q : ret_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      done       <= 1'b0;
      undef      <= 1'b0;
      aborted    <= 1'b0;
      misaligned <= 1'b0;
      pc_o       <= '0;
      lr_o       <= '0;
      sp_o       <= '0;
      ipsr_o     <= '0;
      secure_o   <= 1'b1;
      base_q     <= '0;
      ret_q      <= '0;
      psr_q      <= '0;
      tgt_q      <= '0;
      exc_q      <= '0;
      hnd_q      <= 1'b0;
      mis_q      <= 1'b0;
    end else begin
      done       <= 1'b0;
      undef      <= 1'b0;
      aborted    <= 1'b0;
      misaligned <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (!cur_secure) begin
            undef <= 1'b1;
          end else if (tgt_addr[0]) begin
            done     <= 1'b1;
            lr_o     <= next_pc | 32'd1;
            pc_o     <= {tgt_addr[31:1], 1'b0};
            sp_o     <= sp_in;
            ipsr_o   <= exc_num;
            secure_o <= 1'b1;
          end else begin
            base_q <= base_n;
            ret_q  <= next_pc | 32'd1;
            psr_q  <= psr_n;
            tgt_q  <= tgt_addr[31:1];
            exc_q  <= exc_num;
            hnd_q  <= handler_mode;
            mis_q  <= (base_n[2:0] != 3'd0);
            st     <= S_RET;
          end
        end
        S_RET: if (xfer) begin
          if (mem_fault) begin
            aborted    <= 1'b1;
            misaligned <= mis_q;
            st         <= S_IDLE;
          end else begin
            st <= S_PSR;
          end
        end
        S_PSR: if (xfer) begin
          misaligned <= mis_q;
          st         <= S_IDLE;
          if (mem_fault) begin
            aborted <= 1'b1;
          end else begin
            done     <= 1'b1;
            sp_o     <= base_q;
            lr_o     <= NS_RET_TOKEN;
            pc_o     <= {tgt_q, 1'b0};
            ipsr_o   <= hnd_q ? EXC_W'(1) : exc_q;
            secure_o <= 1'b0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r11_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_wdata)));

  a_r5_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, undef, aborted}));

  a_r7_undef_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    undef |-> ($stable(pc_o) && $stable(lr_o) && $stable(sp_o) && $stable(ipsr_o) && $stable(secure_o)));

  a_r9_abort_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    aborted |-> ($stable(pc_o) && $stable(lr_o) && $stable(sp_o) && $stable(ipsr_o) && $stable(secure_o)));

  a_r8_flag_with_end: assert property (@(posedge clk) disable iff (!rst_n)
    misaligned |-> (done || aborted));

  a_r5_ns_token: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !secure_o) |-> (lr_o == NS_RET_TOKEN && !mem_valid));

endmodule

// File: tb/sec_call_seq_tb_top.sv
module sec_call_seq_tb_top;
  localparam int EXC_W = 9;

  typedef struct packed {
    logic [31:0]      tgt;
    logic [31:0]      npc;
    logic [31:0]      sp;
    logic [EXC_W-1:0] exc;
    logic             fp;
    logic             hnd;
    logic             sec;
    logic [1:0]       flt;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{32'h0000_2001, 32'h1000_0104, 32'h2000_1000, 9'h000, 1'b0, 1'b0, 1'b1, 2'd0},
    '{32'h0000_4000, 32'h1000_0200, 32'h2000_2000, 9'h005, 1'b1, 1'b1, 1'b1, 2'd0},
    '{32'h0000_6000, 32'h1000_0300, 32'h2000_3004, 9'h000, 1'b0, 1'b0, 1'b1, 2'd0},
    '{32'h0000_8000, 32'h1000_0400, 32'h2000_4000, 9'h003, 1'b0, 1'b1, 1'b0, 2'd0},
    '{32'h0000_A000, 32'h1000_0500, 32'h2000_5000, 9'h010, 1'b1, 1'b1, 1'b1, 2'd1},
    '{32'h0000_C000, 32'h1000_0600, 32'h2000_6002, 9'h011, 1'b0, 1'b0, 1'b1, 2'd2},
    '{32'h0001_0000, 32'h1000_0700, 32'h2000_7000, 9'h1FF, 1'b0, 1'b0, 1'b1, 2'd0},
    '{32'h0001_2003, 32'h1000_0801, 32'h2000_8000, 9'h021, 1'b1, 1'b1, 1'b1, 2'd0}
  };

  logic clk = 1'b0;
  always #2ns clk = ~clk;

  logic             rst_n = 1'b0, start = 1'b0;
  logic [31:0]      tgt_addr = '0, next_pc = '0, sp_in = '0;
  logic [EXC_W-1:0] exc_num = '0;
  logic             sfp_active = 1'b0, handler_mode = 1'b0, cur_secure = 1'b1;
  logic             mem_valid, mem_ready, mem_fault;
  logic [31:0]      mem_addr, mem_wdata;
  logic             done, undef, aborted, misaligned, secure_o;
  logic [31:0]      pc_o, lr_o, sp_o;
  logic [EXC_W-1:0] ipsr_o;

  logic       ready_en = 1'b1;
  logic [1:0] flt_sel = '0;
  logic       clr_log = 1'b0;
  logic [1:0] hs;
  int         nwr;
  logic [31:0] wa [2];
  logic [31:0] wd [2];

  assign mem_ready = ready_en;
  assign mem_fault = (flt_sel != 2'd0) && (hs == flt_sel - 2'd1);

  always @(posedge clk) begin
    if (clr_log) begin
      hs  <= '0;
      nwr <= 0;
    end else if (mem_valid && mem_ready) begin
      hs <= hs + 2'd1;
      if (!mem_fault && nwr < 2) begin
        wa[nwr] <= mem_addr;
        wd[nwr] <= mem_wdata;
        nwr     <= nwr + 1;
      end
    end
  end

  sec_call_seq #(.EXC_W(EXC_W)) dut_i (
    .clk, .rst_n, .start, .tgt_addr, .next_pc, .sp_in, .exc_num, .sfp_active,
    .handler_mode, .cur_secure, .mem_valid, .mem_addr, .mem_wdata, .mem_ready,
    .mem_fault, .done, .undef, .aborted, .misaligned, .pc_o, .lr_o, .sp_o,
    .ipsr_o, .secure_o);

  int checks = 0, errors = 0;
  logic [31:0] m_pc = '0, m_lr = '0, m_sp = '0;
  logic [EXC_W-1:0] m_ipsr = '0;
  logic m_sec = 1'b1;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_state(string req);
    chk({req, " pc"}, pc_o, m_pc);
    chk({req, " lr"}, lr_o, m_lr);
    chk({req, " sp"}, sp_o, m_sp);
    chk({req, " ipsr"}, 32'(ipsr_o), 32'(m_ipsr));
    chk({req, " secure"}, 32'(secure_o), 32'(m_sec));
  endtask

  task automatic launch(vec_t v);
    clr_log = 1'b1;
    @(negedge clk);
    clr_log = 1'b0;
    flt_sel = v.flt;
    tgt_addr = v.tgt; next_pc = v.npc; sp_in = v.sp; exc_num = v.exc;
    sfp_active = v.fp; handler_mode = v.hnd; cur_secure = v.sec;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 20; i++) begin
      if (done || undef || aborted) break;
      @(negedge clk);
    end
  endtask

  task automatic run_vec(vec_t v);
    logic [31:0] base, psr;
    logic [2:0]  kind;
    int          expw;
    logic        mis;
    base = v.sp - 32'd8;
    psr  = 32'(v.exc) | (32'(v.fp) << 20);
    mis  = 1'b0;
    expw = 0;
    launch(v);
    wait_end();
    if (!v.sec) begin
      kind = 3'b010;
    end else if (v.tgt[0]) begin
      kind = 3'b100;
      m_lr = v.npc | 32'd1; m_pc = {v.tgt[31:1], 1'b0};
      m_sp = v.sp; m_ipsr = v.exc; m_sec = 1'b1;
    end else begin
      mis = (base[2:0] != 3'd0);
      if (v.flt == 2'd1) begin
        kind = 3'b001;
      end else if (v.flt == 2'd2) begin
        kind = 3'b001; expw = 1;
      end else begin
        kind = 3'b100; expw = 2;
        m_sp = base; m_lr = 32'hFEFF_FFFF; m_pc = {v.tgt[31:1], 1'b0};
        m_ipsr = v.hnd ? EXC_W'(1) : v.exc; m_sec = 1'b0;
      end
    end
    // R2 R5 R7 R9: outcome pulse
    chk("R2/R5/R7/R9 outcome", 32'({done, undef, aborted}), 32'(kind));
    // R8
    chk("R8 misaligned", 32'(misaligned), 32'(mis));
    // R2 R5 R6 R7 R9 state outputs
    chk_state("R2/R5/R6/R7/R9 state");
    @(negedge clk);
    // R3 R9 R2 R7 write count
    chk("R3/R9 write count", 32'(nwr), 32'(expw));
    if (expw >= 1) begin
      chk("R3 ret addr", wa[0], base);
      chk("R3 ret data", wd[0], v.npc | 32'd1);
    end
    if (expw == 2) begin
      chk("R3 psr addr", wa[1], base + 32'd4);
      chk("R4 psr data", wd[1], psr);
    end
  endtask

  initial begin
    #(4ns * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk_state("R1 reset");
    chk("R1 pulses", 32'({done, undef, aborted, misaligned, mem_valid}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    foreach (VECS[i]) run_vec(VECS[i]);

    begin
      vec_t a, b;
      logic [31:0] a0, d0;
      a = '{32'h0002_0000, 32'h1000_0900, 32'h2000_9000, 9'h007, 1'b1, 1'b0, 1'b1, 2'd0};
      b = '{32'h0003_0001, 32'h1000_0A00, 32'h2000_A000, 9'h002, 1'b0, 1'b0, 1'b1, 2'd0};
      ready_en = 1'b0;
      launch(a);
      a0 = mem_addr; d0 = mem_wdata;
      tgt_addr = b.tgt; next_pc = b.npc; sp_in = b.sp; exc_num = b.exc;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (2) @(negedge clk);
      // R11 stalled request held
      chk("R11 valid held", 32'(mem_valid), 32'd1);
      chk("R11 addr held", mem_addr, a0);
      chk("R11 data held", mem_wdata, d0);
      // R10: no pulse from the second start
      chk("R10 no early end", 32'({done, undef, aborted}), 32'd0);
      ready_en = 1'b1;
      wait_end();
      m_sp = 32'h2000_8FF8; m_lr = 32'hFEFF_FFFF; m_pc = 32'h0002_0000;
      m_ipsr = 9'h007; m_sec = 1'b0;
      chk("R10 first call done", 32'(done), 32'd1);
      chk_state("R10 first call kept");
      @(negedge clk);
      chk("R10 writes", 32'(nwr), 32'd2);
      chk("R10 psr data", wd[1], 32'h0010_0007);
      repeat (3) @(negedge clk);
      chk("R10 no late pulse", 32'({done, undef, aborted}), 32'd0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule